// File: doc/BRIEF.md
# SPI Slave-Select and Write-Collision Controller

This block sits beside the shift engine of an SPI port. It produces the internal slave-select level, taken either from the external select pin after a two-stage synchronizer or from a software-written level bit. It also decides whether each write of the data register may load the shift register. A write that is refused is dropped and sets a sticky write-collision flag.

The load rule depends on the clock phase. When data is captured on the second clock edge (CPHA=1), select may stay low across many bytes and a write between bytes is legal. When data is captured on the first edge (CPHA=0), a slave must see select go high between bytes before it may reload. A write while a byte is shifting is always refused. In master mode the internal select must stay high, and a low level there is reported as a configuration error.

A three-state machine tracks the gap between bytes. The states are SLOT_ARMED (reload allowed), SLOT_SHIFT (a byte is in progress) and SLOT_HELD (the byte is done but select has not been released). The transitions are:
- ARMED to SHIFT when busy is high.
- SHIFT to ARMED when busy drops and select is high.
- SHIFT to HELD when busy drops and select is low.
- HELD to SHIFT when busy is high.
- HELD to ARMED when select is high.

Top module: `spi_ss_guard`

## Requirements
- R1: With `cfg_sw_sel_i`=0, `ss_int_o` equals `ss_pin_i` as it was two clock edges earlier (two synchronizer stages).
- R2: With `cfg_sw_sel_i`=1, `ss_int_o` equals `cfg_sw_level_i` in the same cycle, and changes on `ss_pin_i` have no effect on it.
- R3: `cfg_err_o` is 1 exactly when `cfg_master_i`=1 and `ss_int_o`=0.
- R4: A write (`dr_wr_i`=1) while `byte_busy_i`=1 is a collision in either CPHA setting. `load_o` stays 0 and `wcol_o` is 1 from the next clock edge.
- R5: In slave mode with `cfg_cpha_i`=1, a write while `byte_busy_i`=0 gives `load_o`=1 in the same cycle and no collision, even when select has stayed low across bytes.
- R6: In slave mode with `cfg_cpha_i`=0, a write after a byte has ended, while select has stayed low ever since that byte, is a collision.
- R7: In slave mode with `cfg_cpha_i`=0, a write after select has gone high at least once since the last byte ended is legal, even if select is low again at the time of the write. This holds for both select sources.
- R8: In slave mode with `cfg_cpha_i`=0, a write while `ss_int_o`=1 and `byte_busy_i`=0 is legal.
- R9: `wcol_o` stays 1 until a cycle with `wcol_clr_i`=1. When a collision and a clear occur in the same cycle, the flag stays 1.
- R10: In master mode, a write while `byte_busy_i`=0 is legal whatever the select history.
- R11: After reset, `ss_int_o`=1 with pin selection, `wcol_o`=0, and the first write in CPHA=0 slave mode is legal (the tracker starts armed).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sw_sel_i | input | 1 | 1: select comes from the software level bit; 0: select comes from the pin |
| cfg_sw_level_i | input | 1 | Software-driven select level |
| cfg_master_i | input | 1 | 1: master mode; 0: slave mode |
| cfg_cpha_i | input | 1 | Clock phase: 0 = capture on first edge, 1 = capture on second edge |
| ss_pin_i | input | 1 | External select pin (asynchronous) |
| byte_busy_i | input | 1 | High while the shift engine is transferring a byte |
| dr_wr_i | input | 1 | Data register write strobe |
| wcol_clr_i | input | 1 | Clears the write-collision flag |
| ss_int_o | output | 1 | Internal slave-select level |
| load_o | output | 1 | Accepted write: load the shift register this cycle |
| wcol_o | output | 1 | Sticky write-collision flag |
| cfg_err_o | output | 1 | Master mode with the internal select low |

## Verification
The bench targets the gap between bytes in CPHA=0 mode. A select pulse that rises and falls again before the write must still arm the reload; a design that checks only the current level would refuse that write. A write in the same cycle that select rises must also pass; a design that waits for the registered state would flag a false collision there. The bench checks that a collision and a clear in the same cycle keep the flag set, since a design that gives the clear priority would lose the event. It also checks that the pin is ignored under software selection, and that the pin path has exactly two cycles of latency, catching both a missing and an extra stage.

// File: rtl/spi_ss_pkg.sv
package spi_ss_pkg;
    typedef enum logic [1:0] {
        SLOT_ARMED = 2'd0,
        SLOT_SHIFT = 2'd1,
        SLOT_HELD  = 2'd2
    } slot_state_e;
endpackage

// File: rtl/spi_ss_sync.sv
module spi_ss_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi_ss_slot_fsm.sv
module spi_ss_slot_fsm
    import spi_ss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic ss_i,
    output logic armed_o
);
    slot_state_e state, state_nx;

    // Next state: a byte start always wins; select high re-arms the reload (R6, R7).
    always_comb begin
        state_nx = state;
        unique case (state)
            SLOT_ARMED: if (busy_i) state_nx = SLOT_SHIFT;
            SLOT_SHIFT: if (!busy_i) state_nx = ss_i ? SLOT_ARMED : SLOT_HELD;
            SLOT_HELD: begin
                if (busy_i)    state_nx = SLOT_SHIFT;
                else if (ss_i) state_nx = SLOT_ARMED;
            end
            default:    state_nx = SLOT_ARMED;
        endcase
    end

    // State register; the tracker starts armed (R11).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SLOT_ARMED;
        else        state <= state_nx;
    end

    // Outputs.
    always_comb begin
        armed_o = 1'b0;
        unique case (state)
            SLOT_ARMED: armed_o = 1'b1;
            SLOT_SHIFT: armed_o = 1'b0;
            SLOT_HELD:  armed_o = 1'b0;
            default:    armed_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/spi_ss_wcol.sv
module spi_ss_wcol (
    input  logic clk,
    input  logic rst_n,
    input  logic master_i,
    input  logic cpha_i,
    input  logic busy_i,
    input  logic armed_i,
    input  logic ss_i,
    input  logic wr_i,
    input  logic clr_i,
    output logic load_o,
    output logic wcol_o
);
    logic gap_ok;
    logic phase_block;
    logic collide;

    // A high select right now also counts as a release (R8).
    assign gap_ok      = armed_i | ss_i;
    // Only a CPHA=0 slave needs the release between bytes (R5, R6, R10).
    assign phase_block = ~master_i & ~cpha_i & ~gap_ok;
    // A write during a byte always collides (R4).
    assign collide     = wr_i & (busy_i | phase_block);
    assign load_o      = wr_i & ~collide;

    // Sticky flag; a new collision beats a clear (R9).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       wcol_o <= 1'b0;
        else if (collide) wcol_o <= 1'b1;
        else if (clr_i)   wcol_o <= 1'b0;
    end
endmodule

// File: rtl/spi_ss_guard.sv
module spi_ss_guard #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_sw_sel_i,
    input  logic cfg_sw_level_i,
    input  logic cfg_master_i,
    input  logic cfg_cpha_i,
    input  logic ss_pin_i,
    input  logic byte_busy_i,
    input  logic dr_wr_i,
    input  logic wcol_clr_i,
    output logic ss_int_o,
    output logic load_o,
    output logic wcol_o,
    output logic cfg_err_o
);
    logic pin_sync;
    logic armed;

    // R1: pin path through the synchronizer, reset to the released level.
    spi_ss_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ss_pin_i),
        .q_o   (pin_sync)
    );

    // R2: the software source bypasses the pin entirely.
    assign ss_int_o  = cfg_sw_sel_i ? cfg_sw_level_i : pin_sync;
    // R3
    assign cfg_err_o = cfg_master_i & ~ss_int_o;

    spi_ss_slot_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_i  (byte_busy_i),
        .ss_i    (ss_int_o),
        .armed_o (armed)
    );

    spi_ss_wcol u_wcol (
        .clk      (clk),
        .rst_n    (rst_n),
        .master_i (cfg_master_i),
        .cpha_i   (cfg_cpha_i),
        .busy_i   (byte_busy_i),
        .armed_i  (armed),
        .ss_i     (ss_int_o),
        .wr_i     (dr_wr_i),
        .clr_i    (wcol_clr_i),
        .load_o   (load_o),
        .wcol_o   (wcol_o)
    );
endmodule

// File: rtl/spi_ss_guard_chk.sv
module spi_ss_guard_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cfg_sw_sel_i,
    input logic cfg_sw_level_i,
    input logic cfg_master_i,
    input logic cfg_cpha_i,
    input logic ss_pin_i,
    input logic byte_busy_i,
    input logic dr_wr_i,
    input logic wcol_clr_i,
    input logic ss_int_o,
    input logic load_o,
    input logic wcol_o,
    input logic cfg_err_o
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_pin_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && !cfg_sw_sel_i) |-> (ss_int_o == $past(ss_pin_i, 2)));

    assert_sw_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sw_sel_i |-> (ss_int_o == cfg_sw_level_i));

    assert_master_high_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master_i && ss_int_o) |-> !cfg_err_o);

    assert_busy_no_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_busy_i && dr_wr_i) |-> !load_o);

    assert_busy_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_busy_i && dr_wr_i) |=> wcol_o);

    assert_cpha1_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_master_i && cfg_cpha_i && dr_wr_i && !byte_busy_i) |-> load_o);

    assert_high_ss_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_master_i && dr_wr_i && !byte_busy_i && ss_int_o) |-> load_o);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wcol_o && !wcol_clr_i) |=> wcol_o);

    assert_master_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master_i && dr_wr_i && !byte_busy_i) |-> load_o);

    assert_load_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> dr_wr_i);
endmodule

bind spi_ss_guard spi_ss_guard_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/spi_ss_guard_tb.sv
module spi_ss_guard_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_sw_sel = 1'b0, cfg_sw_level = 1'b1, cfg_master = 1'b0, cfg_cpha = 1'b0;
    logic ss_pin = 1'b1, byte_busy = 1'b0, dr_wr = 1'b0, wcol_clr = 1'b0;
    logic ss_int, load, wcol, cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_ss_guard u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_sw_sel_i(cfg_sw_sel), .cfg_sw_level_i(cfg_sw_level),
        .cfg_master_i(cfg_master), .cfg_cpha_i(cfg_cpha),
        .ss_pin_i(ss_pin), .byte_busy_i(byte_busy),
        .dr_wr_i(dr_wr), .wcol_clr_i(wcol_clr),
        .ss_int_o(ss_int), .load_o(load), .wcol_o(wcol), .cfg_err_o(cfg_err)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Write strobe for one cycle; load checked in-cycle, flag after the edge.
    task automatic do_write(input string req, input logic exp_load, input logic exp_wcol);
        @(negedge clk);
        dr_wr = 1'b1;
        #1 check(req, "load_o", load, exp_load);
        @(negedge clk);
        dr_wr = 1'b0;
        #1 check(req, "wcol_o", wcol, exp_wcol);
    endtask

    task automatic do_byte(input int len);
        @(negedge clk);
        byte_busy = 1'b1;
        repeat (len) @(negedge clk);
        byte_busy = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_flag(input string req);
        @(negedge clk);
        wcol_clr = 1'b1;
        @(negedge clk);
        wcol_clr = 1'b0;
        #1 check(req, "wcol_o cleared", wcol, 1'b0);
    endtask

    task automatic t_reset;
        #1;
        check("R11", "ss_int_o at reset", ss_int, 1'b1);
        check("R11", "wcol_o at reset", wcol, 1'b0);
        check("R11", "load_o at reset", load, 1'b0);
        check("R3", "cfg_err_o at reset", cfg_err, 1'b0);
    endtask

    task automatic t_first_write_r11;
        cfg_sw_sel = 1'b1; cfg_sw_level = 1'b0; cfg_cpha = 1'b0;
        do_write("R11", 1'b1, 1'b0);
    endtask

    task automatic t_pin_r1;
        cfg_sw_sel = 1'b0;
        tick(3);
        @(negedge clk);
        ss_pin = 1'b0;
        tick(1);
        check("R1", "ss_int_o after one edge", ss_int, 1'b1);
        tick(1);
        check("R1", "ss_int_o after two edges", ss_int, 1'b0);
        ss_pin = 1'b1;
        tick(2);
        check("R1", "ss_int_o back high", ss_int, 1'b1);
    endtask

    task automatic t_sw_r2;
        @(negedge clk);
        cfg_sw_sel = 1'b1; cfg_sw_level = 1'b0;
        #1 check("R2", "ss_int_o follows level 0", ss_int, 1'b0);
        ss_pin = 1'b1;
        tick(3);
        check("R2", "pin high ignored", ss_int, 1'b0);
        cfg_sw_level = 1'b1; ss_pin = 1'b0;
        tick(3);
        check("R2", "pin low ignored", ss_int, 1'b1);
        ss_pin = 1'b1;
        tick(3);
    endtask

    task automatic t_cfg_err_r3;
        @(negedge clk);
        cfg_sw_sel = 1'b1; cfg_master = 1'b1; cfg_sw_level = 1'b0;
        #1 check("R3", "master with select low", cfg_err, 1'b1);
        cfg_sw_level = 1'b1;
        #1 check("R3", "master with select high", cfg_err, 1'b0);
        cfg_master = 1'b0; cfg_sw_level = 1'b0;
        #1 check("R3", "slave with select low", cfg_err, 1'b0);
    endtask

    task automatic t_busy_r4(input logic cpha);
        cfg_master = 1'b0; cfg_cpha = cpha; cfg_sw_sel = 1'b1; cfg_sw_level = 1'b0;
        @(negedge clk);
        byte_busy = 1'b1;
        do_write("R4", 1'b0, 1'b1);
        byte_busy = 1'b0;
        tick(1);
        clear_flag("R4");
    endtask

    task automatic t_cpha1_r5;
        cfg_master = 1'b0; cfg_cpha = 1'b1; cfg_sw_sel = 1'b1; cfg_sw_level = 1'b0;
        do_byte(4);
        do_write("R5", 1'b1, 1'b0);
        do_byte(4);
        do_write("R5", 1'b1, 1'b0);
    endtask

    task automatic t_cpha0_held_r6;
        cfg_master = 1'b0; cfg_cpha = 1'b0; cfg_sw_sel = 1'b1; cfg_sw_level = 1'b0;
        do_byte(4);
        do_write("R6", 1'b0, 1'b1);
        clear_flag("R6");
    endtask

    task automatic t_cpha0_pulse_r7;
        cfg_master = 1'b0; cfg_cpha = 1'b0; cfg_sw_sel = 1'b1; cfg_sw_level = 1'b0;
        do_byte(4);
        cfg_sw_level = 1'b1;
        @(negedge clk);
        cfg_sw_level = 1'b0;
        do_write("R7", 1'b1, 1'b0);
        // same through the pin path
        cfg_sw_sel = 1'b0; ss_pin = 1'b0;
        tick(3);
        do_byte(4);
        ss_pin = 1'b1;
        tick(3);
        ss_pin = 1'b0;
        tick(3);
        check("R7", "pin select low again", ss_int, 1'b0);
        do_write("R7", 1'b1, 1'b0);
        ss_pin = 1'b1;
        tick(3);
    endtask

    task automatic t_cpha0_high_r8;
        cfg_master = 1'b0; cfg_cpha = 1'b0; cfg_sw_sel = 1'b1; cfg_sw_level = 1'b0;
        do_byte(4);
        @(negedge clk);
        cfg_sw_level = 1'b1;
        dr_wr = 1'b1;
        #1 check("R8", "load_o with select rising this cycle", load, 1'b1);
        @(negedge clk);
        dr_wr = 1'b0;
        #1 check("R8", "wcol_o stays clear", wcol, 1'b0);
    endtask

    task automatic t_sticky_r9;
        cfg_master = 1'b0; cfg_cpha = 1'b1; cfg_sw_sel = 1'b1; cfg_sw_level = 1'b0;
        @(negedge clk);
        byte_busy = 1'b1;
        do_write("R9", 1'b0, 1'b1);
        tick(4);
        check("R9", "flag held without clear", wcol, 1'b1);
        @(negedge clk);
        dr_wr = 1'b1; wcol_clr = 1'b1;
        @(negedge clk);
        dr_wr = 1'b0; wcol_clr = 1'b0;
        #1 check("R9", "collision beats clear", wcol, 1'b1);
        byte_busy = 1'b0;
        clear_flag("R9");
    endtask

    task automatic t_master_r10;
        cfg_master = 1'b1; cfg_cpha = 1'b0; cfg_sw_sel = 1'b1; cfg_sw_level = 1'b0;
        do_byte(4);
        do_write("R10", 1'b1, 1'b0);
        cfg_master = 1'b0; cfg_sw_level = 1'b1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        tick(2);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_first_write_r11();
        t_pin_r1();
        t_sw_r2();
        t_cfg_err_r3();
        t_busy_r4(1'b0);
        t_busy_r4(1'b1);
        t_cpha1_r5();
        t_cpha0_held_r6();
        t_cpha0_pulse_r7();
        t_cpha0_high_r8();
        t_sticky_r9();
        t_master_r10();
        tick(2);
        finish_run();
    end
endmodule